// File: doc/BRIEF.md
# Antenna Select Controller for Channel Check and Transmit

This block drives a single antenna-select line for a two-antenna radio front end. The same selection is used for the clear-channel check and for the transmission that follows it, so the transmit antenna always matches the checked antenna. A 2-bit mode input picks the policy. One policy replays the antenna that last carried a valid header and lets the diversity logic flip the acquisition antenna. The other two policies pin the line to antenna A or to antenna B.

The block keeps a memory of the antenna that was active on the most recent header-valid pulse. That memory is updated in every mode, so returning to the replay policy resumes on the last good antenna. While transmit enable is high, the output is frozen at the value it had when transmission began. The one unused mode code is treated as the replay policy, and it latches an error flag that only reset clears.

Top module: `ant_cca_ctrl`

## Requirements
- R1: After reset, ant_sel_o is 1 (antenna A), mode_err_o is 0, and the remembered header antenna is A.
- R2: With mode_i = 2'b10 and tx_en_i low at a clock edge, ant_sel_o is 0 (antenna B) after that edge.
- R3: With mode_i = 2'b11 and tx_en_i low at a clock edge, ant_sel_o is 1 (antenna A) after that edge.
- R4: A hdr_valid_i pulse stores hdr_ant_i (1 = A, 0 = B) in any mode. In replay mode (2'b00) with tx_en_i low, ant_sel_o equals the stored antenna after that edge. On a return to replay mode, ant_sel_o shows the last stored antenna.
- R5: In replay mode with tx_en_i low, acq_toggle_i inverts ant_sel_o after the edge. In modes 2'b10 and 2'b11, and while tx_en_i is high, acq_toggle_i has no effect on ant_sel_o now or after a later return to replay mode.
- R6: When hdr_valid_i and acq_toggle_i are both high at the same edge in replay mode, the header antenna wins and the toggle is dropped.
- R7: While tx_en_i is high, ant_sel_o holds the value it had before the first edge with tx_en_i high. Mode changes during that time are ignored until tx_en_i falls.
- R8: mode_i = 2'b01 selects exactly as replay mode does, and it sets mode_err_o from the next edge on. The flag stays set until reset, whatever mode follows.
- R9: A header captured while tx_en_i is high has no effect on the output during transmit. It appears on ant_sel_o after the first edge in replay mode with tx_en_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Selection policy: 00 replay, 01 illegal (acts as replay), 10 antenna B, 11 antenna A |
| hdr_valid_i | input | 1 | One-cycle pulse when a valid header is received |
| hdr_ant_i | input | 1 | Antenna active during the header (1 = A, 0 = B) |
| acq_toggle_i | input | 1 | Diversity request to flip the acquisition antenna |
| tx_en_i | input | 1 | Transmit enable; freezes the select line while high |
| ant_sel_o | output | 1 | Antenna select (1 = A, 0 = B) |
| mode_err_o | output | 1 | Sticky flag set by the illegal mode code |

## Verification
A header-valid pulse and a diversity toggle can arrive in the same cycle, and both try to rewrite the acquisition antenna. The bench drives both together in replay mode, once with each header antenna value. Its reference model expects the header antenna to win every time. A header captured during transmit also collides with the output freeze, so the bench checks that the output stays frozen and that the captured antenna appears only once transmit enable falls.

// File: rtl/ant_cca_pkg.sv
package ant_cca_pkg;
  localparam int unsigned ModeW = 2;

  typedef enum logic [ModeW-1:0] {
    MODE_REPLAY  = 2'b00,
    MODE_BAD     = 2'b01,
    MODE_FORCE_B = 2'b10,
    MODE_FORCE_A = 2'b11
  } ant_mode_e;

  localparam logic ANT_A = 1'b1;
  localparam logic ANT_B = 1'b0;
endpackage

// File: rtl/ant_mode_dec.sv
module ant_mode_dec
  import ant_cca_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ModeW-1:0] mode_i,
  output logic             replay_o,
  output logic             force_val_o,
  output logic             err_o
);
  logic err_q;

  always_comb begin
    replay_o    = (mode_i == MODE_REPLAY) || (mode_i == MODE_BAD);
    force_val_o = (mode_i == MODE_FORCE_A) ? ANT_A : ANT_B;
  end

  // sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   err_q <= 1'b0;
    else if (mode_i == MODE_BAD)   err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/ant_hdr_mem.sv
module ant_hdr_mem
  import ant_cca_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hdr_valid_i,
  input  logic hdr_ant_i,
  input  logic replay_i,
  input  logic toggle_i,
  input  logic tx_en_i,
  output logic acq_d_o
);
  logic last_q;
  logic acq_q;
  logic acq_d;

  // header beats toggle; forced modes resync acquisition to last header
  always_comb begin
    if (hdr_valid_i)                      acq_d = hdr_ant_i;
    else if (!replay_i)                   acq_d = last_q;
    else if (toggle_i && !tx_en_i)        acq_d = ~acq_q;
    else                                  acq_d = acq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= ANT_A;
      acq_q  <= ANT_A;
    end else begin
      if (hdr_valid_i) last_q <= hdr_ant_i;
      acq_q <= acq_d;
    end
  end

  assign acq_d_o = acq_d;
endmodule

// File: rtl/ant_sel_hold.sv
module ant_sel_hold
  import ant_cca_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic replay_i,
  input  logic force_val_i,
  input  logic acq_d_i,
  output logic ant_sel_o
);
  logic sel_q;
  logic sel_d;

  assign sel_d = replay_i ? acq_d_i : force_val_i;

  // frozen for the whole transmit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= ANT_A;
    else if (!tx_en_i) sel_q <= sel_d;
  end

  assign ant_sel_o = sel_q;
endmodule

// File: rtl/ant_cca_ctrl.sv
module ant_cca_ctrl
  import ant_cca_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ModeW-1:0] mode_i,
  input  logic             hdr_valid_i,
  input  logic             hdr_ant_i,
  input  logic             acq_toggle_i,
  input  logic             tx_en_i,
  output logic             ant_sel_o,
  output logic             mode_err_o
);
  logic replay;
  logic force_val;
  logic acq_d;

  ant_mode_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .replay_o    (replay),
    .force_val_o (force_val),
    .err_o       (mode_err_o)
  );

  ant_hdr_mem u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_valid_i (hdr_valid_i),
    .hdr_ant_i   (hdr_ant_i),
    .replay_i    (replay),
    .toggle_i    (acq_toggle_i),
    .tx_en_i     (tx_en_i),
    .acq_d_o     (acq_d)
  );

  ant_sel_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .replay_i    (replay),
    .force_val_i (force_val),
    .acq_d_i     (acq_d),
    .ant_sel_o   (ant_sel_o)
  );
endmodule

// File: rtl/ant_cca_chk.sv
module ant_cca_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       hdr_valid_i,
  input logic       hdr_ant_i,
  input logic       tx_en_i,
  input logic       ant_sel_o,
  input logic       mode_err_o
);
  AST_FORCE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && mode_i == 2'b10) |=> !ant_sel_o); // R2

  AST_FORCE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && mode_i == 2'b11) |=> ant_sel_o); // R3

  AST_HDR_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !tx_en_i && !mode_i[1]) |=> (ant_sel_o == $past(hdr_ant_i))); // R6

  AST_TX_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> $stable(ant_sel_o)); // R7

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> mode_err_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |=> mode_err_o); // R8
endmodule

bind ant_cca_ctrl ant_cca_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .hdr_valid_i (hdr_valid_i),
  .hdr_ant_i   (hdr_ant_i),
  .tx_en_i     (tx_en_i),
  .ant_sel_o   (ant_sel_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/sim_ant_cca_ctrl.sv
`timescale 1ns/1ps
module sim_ant_cca_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hv = 1'b0, ha = 1'b0, tog = 1'b0, tx = 1'b0;
  logic       sel, err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit    q_sel[$];
  bit    q_err[$];
  string q_tag[$];

  // reference state
  bit m_last, m_acq, m_sel, m_err;

  always #2 clk = ~clk;

  ant_cca_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .hdr_valid_i(hv),
    .hdr_ant_i(ha), .acq_toggle_i(tog), .tx_en_i(tx),
    .ant_sel_o(sel), .mode_err_o(err)
  );

  task automatic check(input bit s, input bit e, input string tag);
    n_run++;
    if (sel !== s || err !== e) begin
      n_fail++;
      $display("FAIL %s sel=%0b exp=%0b err=%0b exp=%0b", tag, sel, s, err, e);
    end
  endtask

  task automatic model_reset();
    m_last = 1'b1; m_acq = 1'b1; m_sel = 1'b1; m_err = 1'b0;
  endtask

  // apply one cycle of stimulus and queue the expected result
  task automatic drive(input bit [1:0] md, input bit h, input bit a,
                       input bit t, input bit x, input string tag);
    bit replay, nxt;
    @(negedge clk);
    mode = md; hv = h; ha = a; tog = t; tx = x;
    replay = !md[1];
    if (md == 2'b01) m_err = 1'b1;
    if (h) begin m_last = a; m_acq = a; end
    else if (!replay) m_acq = m_last;
    else if (t && !x) m_acq = ~m_acq;
    nxt = (md == 2'b10) ? 1'b0 : (md == 2'b11) ? 1'b1 : m_acq;
    if (!x) m_sel = nxt;
    q_sel.push_back(m_sel); q_err.push_back(m_err); q_tag.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    if (q_sel.size() > 0) begin
      bit s, e; string tg;
      s = q_sel.pop_front(); e = q_err.pop_front(); tg = q_tag.pop_front();
      #1 check(s, e, tg);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(1'b1, 1'b0, "R1 reset");
    rst_n = 1'b1;
    drive(2'b00, 0, 0, 0, 0, "R1 idle after reset");
    drive(2'b10, 0, 0, 0, 0, "R2 force B");
    drive(2'b10, 0, 0, 1, 0, "R5 toggle ignored in force B");
    drive(2'b11, 0, 0, 0, 0, "R3 force A");
    drive(2'b11, 0, 0, 1, 0, "R5 toggle ignored in force A");
    drive(2'b00, 1, 0, 0, 0, "R4 header B replayed");
    drive(2'b10, 1, 1, 0, 0, "R4 header A stored while forced");
    drive(2'b11, 0, 0, 1, 0, "R5 forced toggle");
    drive(2'b00, 0, 0, 0, 0, "R4 return to last header antenna");
    drive(2'b00, 0, 0, 1, 0, "R5 toggle to B");
    drive(2'b00, 0, 0, 1, 0, "R5 toggle to A");
    drive(2'b00, 1, 0, 1, 0, "R6 header B beats toggle");
    drive(2'b00, 1, 1, 1, 0, "R6 header A beats toggle");
    drive(2'b00, 0, 0, 1, 0, "R5 toggle to B before tx");
    drive(2'b11, 0, 0, 0, 1, "R7 mode change frozen in tx");
    drive(2'b00, 0, 0, 1, 1, "R5 toggle ignored in tx");
    drive(2'b00, 1, 1, 0, 1, "R9 header during tx held off");
    drive(2'b00, 0, 0, 0, 0, "R9 header shown after tx");
    drive(2'b01, 0, 0, 0, 0, "R8 illegal sets flag");
    drive(2'b01, 0, 0, 1, 0, "R8 illegal toggles as replay");
    drive(2'b00, 0, 0, 0, 0, "R8 flag sticky in replay");
    drive(2'b10, 0, 0, 0, 0, "R8 flag sticky in force B");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check(1'b1, 1'b0, "R1 second reset");
    rst_n = 1'b1;
    drive(2'b00, 0, 0, 0, 0, "R1 memory back to A");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule